// File: doc/BRIEF.md
# Banked PCS register window

This block sits on the slave side of a simple memory-mapped bus. It exposes a 21-bit clause 45 register space through a small flat window. A full target address is the MMD number shifted left by 16 and OR-ed with a 16-bit register number. The host splits that address in two: the upper 13 bits are the bank, and the lower 8 bits are the offset inside the window.

An access takes two steps. The host first writes the bank value into a bank register that sits at a fixed window location. It then reads or writes one word at the window offset. The block rebuilds the full address and sends one read or write to an internal PCS register file over a request/acknowledge port. Only one forwarded access is open at a time, and `bus_wait` holds further bus requests off until it is done.

The block answers some accesses locally and never forwards them:
- reads of the two identifier registers, which return a constant;
- bank register accesses;
- refused offsets;
- every access to an instance that is configured as absent.

Top module: `pcs_bank_window`

## Requirements
- R1: The bank register sits at window address `BANK_OFFSET` (default 0x3FC). It holds 13 bits and resets to zero. A write loads `bus_wdata[12:0]`, and a read returns the bank zero-extended. A bank access never raises `pcs_req` and gives response code OK (2'b00).
- R2: A data access at window address o < 0xFF forwards `pcs_addr` = {bank, o[7:0]}. That is, the MMD is bank[12:8] and the register is {bank[7:0], o}.
- R3: A forwarded write carries `bus_wdata[15:0]` on `pcs_wdata`. Bits 31:16 of the write data have no effect.
- R4: A forwarded read returns `pcs_rdata` in `bus_rsp_data[15:0]`, with bits 31:16 zero. Every response has its upper 16 data bits at zero.
- R5: A data access at window offset 0xFF answers with code ERR (2'b01) and raises no PCS request. Any other window address that is neither a data offset nor the bank register gets the same answer.
- R6: While the bank is 0x1F00 (MMD 31), a read at offset 0x02 returns the identifier's upper 16 bits and a read at offset 0x03 returns its lower 16 bits. Neither read is forwarded. Writes to these registers are forwarded as usual.
- R7: From acceptance until the PCS acknowledges, `pcs_req` stays high with stable address, direction and data, and `bus_wait` stays high. A request held during that time is accepted only after `bus_wait` falls, and it is accepted once.
- R8: A locally answered access raises `bus_rsp_valid` for one cycle, in the cycle after its acceptance edge. A forwarded access raises `bus_rsp_valid` with code OK in the cycle after the edge that samples `pcs_ack`.
- R9: In an instance built with `PCS_PRESENT` = 0, every access, bank accesses included, answers with code NODEV (2'b10) and no PCS request is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request present; held while `bus_wait` is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Window word address |
| bus_wdata | input | 32 | Write data |
| bus_wait | output | 1 | Request stalled; a forwarded access is open |
| bus_rsp_valid | output | 1 | One-cycle response strobe |
| bus_rsp_code | output | 2 | 00 OK, 01 refused/unmapped, 10 no device |
| bus_rsp_data | output | 32 | Read data, zero-extended |
| pcs_req | output | 1 | Request to the PCS register file |
| pcs_we | output | 1 | Forwarded direction |
| pcs_addr | output | 21 | Full MMD/register address |
| pcs_wdata | output | 16 | Forwarded write data |
| pcs_ack | input | 1 | PCS acknowledge, sampled while `pcs_req` is high |
| pcs_rdata | input | 16 | PCS read data, valid with `pcs_ack` |

## Verification
The bench provokes one case in particular: the response to a finished forwarded read and the acceptance of the next bus request fall in the same cycle. A forwarded read is started with a delayed acknowledge, and a bank write is presented while `bus_wait` is still high. In the cycle after the acknowledge edge, the bench checks four things:
- the read's response carries the PCS data;
- `bus_wait` has already fallen;
- the held bank write is accepted on the next edge and answered one cycle later;
- exactly one PCS transaction took place, and the bank reads back the new value.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

   typedef enum logic [2:0] {
      K_BANK_WR,
      K_BANK_RD,
      K_ID_HI,
      K_ID_LO,
      K_FWD,
      K_REFUSE,
      K_NODEV
   } acc_kind_e;

   typedef enum logic [1:0] {
      RSP_OK    = 2'b00,
      RSP_ERR   = 2'b01,
      RSP_NODEV = 2'b10
   } rsp_code_e;

endpackage

// File: rtl/pbw_decode.sv
module pbw_decode
   import pbw_pkg::*;
#(
   parameter int               WIN_AW      = 10,
   parameter int               OFF_W       = 8,
   parameter int               BANK_W      = 13,
   parameter logic [WIN_AW-1:0] BANK_OFFSET = 10'h3FC,
   parameter logic [BANK_W-1:0] ID_BANK     = 13'h1F00,
   parameter logic [OFF_W-1:0]  ID_HI_OFF   = 8'h02,
   parameter logic [OFF_W-1:0]  ID_LO_OFF   = 8'h03,
   parameter bit               PCS_PRESENT = 1'b1
) (
   input  logic              we,
   input  logic [WIN_AW-1:0] addr,
   input  logic [BANK_W-1:0] bank,
   output acc_kind_e         kind
);

   localparam logic [WIN_AW-1:0] RSV_OFF = WIN_AW'((1 << OFF_W) - 1);

   logic id_bank;
   assign id_bank = (bank == ID_BANK);

   always_comb begin
      if (!PCS_PRESENT) begin
         kind = K_NODEV;
      end else if (addr == BANK_OFFSET) begin
         kind = we ? K_BANK_WR : K_BANK_RD;
      end else if (addr < RSV_OFF) begin
         if (!we && id_bank && addr[OFF_W-1:0] == ID_HI_OFF)
            kind = K_ID_HI;
         else if (!we && id_bank && addr[OFF_W-1:0] == ID_LO_OFF)
            kind = K_ID_LO;
         else
            kind = K_FWD;
      end else begin
         kind = K_REFUSE;
      end
   end

endmodule

// File: rtl/pbw_bank.sv
module pbw_bank #(
   parameter int BANK_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] din,
   output logic [BANK_W-1:0] bank
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bank <= '0;
      else if (load)
         bank <= din;
   end

endmodule

// File: rtl/pbw_fwd.sv
module pbw_fwd #(
   parameter int FULL_W = 21,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              we,
   input  logic [FULL_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic              busy,
   output logic              done,
   output logic [REG_W-1:0]  rdata,
   output logic              pcs_req,
   output logic              pcs_we,
   output logic [FULL_W-1:0] pcs_addr,
   output logic [REG_W-1:0]  pcs_wdata,
   input  logic              pcs_ack,
   input  logic [REG_W-1:0]  pcs_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcs_req   <= 1'b0;
         pcs_we    <= 1'b0;
         pcs_addr  <= '0;
         pcs_wdata <= '0;
      end else if (start && !pcs_req) begin
         pcs_req   <= 1'b1;
         pcs_we    <= we;
         pcs_addr  <= addr;
         pcs_wdata <= wdata;
      end else if (pcs_req && pcs_ack) begin
         pcs_req <= 1'b0;
      end
   end

   assign busy  = pcs_req;
   assign done  = pcs_req && pcs_ack;
   assign rdata = pcs_we ? '0 : pcs_rdata;

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pcs_req && !pcs_ack |=> pcs_req && $stable(pcs_addr) && $stable(pcs_we)
                             && $stable(pcs_wdata));

endmodule

// File: rtl/pcs_bank_window.sv
module pcs_bank_window
   import pbw_pkg::*;
#(
   parameter int               MMD_W       = 5,
   parameter int               REG_W       = 16,
   parameter int               OFF_W       = 8,
   parameter int               WIN_AW      = 10,
   parameter int               DATA_W      = 32,
   parameter logic [WIN_AW-1:0] BANK_OFFSET = 10'h3FC,
   parameter logic [31:0]      ID_VALUE    = 32'hB0CA_7E11,
   parameter int               ID_MMD      = 31,
   parameter int               ID_HI_REG   = 2,
   parameter int               ID_LO_REG   = 3,
   parameter bit               PCS_PRESENT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_valid,
   input  logic                      bus_we,
   input  logic [WIN_AW-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic                      bus_wait,
   output logic                      bus_rsp_valid,
   output logic [1:0]                bus_rsp_code,
   output logic [DATA_W-1:0]         bus_rsp_data,
   output logic                      pcs_req,
   output logic                      pcs_we,
   output logic [MMD_W+REG_W-1:0]    pcs_addr,
   output logic [REG_W-1:0]          pcs_wdata,
   input  logic                      pcs_ack,
   input  logic [REG_W-1:0]          pcs_rdata
);

   localparam int FULL_W = MMD_W + REG_W;
   localparam int BANK_W = FULL_W - OFF_W;
   localparam logic [FULL_W-1:0] ID_HI_FULL = FULL_W'((ID_MMD << REG_W) | ID_HI_REG);
   localparam logic [FULL_W-1:0] ID_LO_FULL = FULL_W'((ID_MMD << REG_W) | ID_LO_REG);
   localparam logic [BANK_W-1:0] ID_BANK    = ID_HI_FULL[FULL_W-1:OFF_W];
   localparam logic [WIN_AW-1:0] RSV_OFF    = WIN_AW'((1 << OFF_W) - 1);

   if (DATA_W <= REG_W) begin : g_chk_dw
      $error("DATA_W must exceed REG_W");
   end
   if (WIN_AW <= OFF_W || int'(BANK_OFFSET) <= int'(RSV_OFF)) begin : g_chk_win
      $error("bank register must lie outside the data window");
   end
   if (REG_W <= OFF_W) begin : g_chk_off
      $error("OFF_W must be narrower than REG_W");
   end
   if (ID_HI_FULL[FULL_W-1:OFF_W] != ID_LO_FULL[FULL_W-1:OFF_W]) begin : g_chk_id
      $error("identifier registers must share a bank");
   end

   acc_kind_e          kind;
   logic [BANK_W-1:0]  bank_q;
   logic               busy, fwd_done, accept, fwd_start;
   logic [REG_W-1:0]   fwd_rdata;

   assign accept    = bus_valid && !busy;
   assign fwd_start = accept && (kind == K_FWD);
   assign bus_wait  = busy;

   pbw_decode #(
      .WIN_AW(WIN_AW), .OFF_W(OFF_W), .BANK_W(BANK_W),
      .BANK_OFFSET(BANK_OFFSET), .ID_BANK(ID_BANK),
      .ID_HI_OFF(ID_HI_FULL[OFF_W-1:0]), .ID_LO_OFF(ID_LO_FULL[OFF_W-1:0]),
      .PCS_PRESENT(PCS_PRESENT)
   ) u_dec (
      .we(bus_we), .addr(bus_addr), .bank(bank_q), .kind(kind)
   );

   pbw_bank #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .load(accept && kind == K_BANK_WR),
      .din(bus_wdata[BANK_W-1:0]),
      .bank(bank_q)
   );

   if (PCS_PRESENT) begin : g_fwd
      pbw_fwd #(.FULL_W(FULL_W), .REG_W(REG_W)) u_fwd (
         .clk(clk), .rst_n(rst_n),
         .start(fwd_start), .we(bus_we),
         .addr({bank_q, bus_addr[OFF_W-1:0]}),
         .wdata(bus_wdata[REG_W-1:0]),
         .busy(busy), .done(fwd_done), .rdata(fwd_rdata),
         .pcs_req(pcs_req), .pcs_we(pcs_we), .pcs_addr(pcs_addr),
         .pcs_wdata(pcs_wdata), .pcs_ack(pcs_ack), .pcs_rdata(pcs_rdata)
      );
   end else begin : g_absent
      assign busy      = 1'b0;
      assign fwd_done  = 1'b0;
      assign fwd_rdata = '0;
      assign pcs_req   = 1'b0;
      assign pcs_we    = 1'b0;
      assign pcs_addr  = '0;
      assign pcs_wdata = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rsp_valid <= 1'b0;
         bus_rsp_code  <= RSP_OK;
         bus_rsp_data  <= '0;
      end else begin
         bus_rsp_valid <= 1'b0;
         if (fwd_done) begin
            bus_rsp_valid <= 1'b1;
            bus_rsp_code  <= RSP_OK;
            bus_rsp_data  <= DATA_W'(fwd_rdata);
         end else if (accept && kind != K_FWD) begin
            bus_rsp_valid <= 1'b1;
            bus_rsp_code  <= RSP_OK;
            bus_rsp_data  <= '0;
            unique case (kind)
               K_BANK_RD: bus_rsp_data <= DATA_W'(bank_q);
               K_ID_HI:   bus_rsp_data <= DATA_W'(ID_VALUE[31:16]);
               K_ID_LO:   bus_rsp_data <= DATA_W'(ID_VALUE[15:0]);
               K_REFUSE:  bus_rsp_code <= RSP_ERR;
               K_NODEV:   bus_rsp_code <= RSP_NODEV;
               default:   bus_rsp_code <= RSP_OK;
            endcase
         end
      end
   end

   assert_fwd_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pcs_req && pcs_ack |=> bus_rsp_valid && bus_rsp_code == RSP_OK);

   assert_no_rsv_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pcs_req) |-> $past(bus_addr) < RSV_OFF);

   assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rsp_valid |-> bus_rsp_data[DATA_W-1:REG_W] == '0);

   assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pcs_req |=> $stable(bank_q));

   assert_wait_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pcs_req) |-> $past(bus_valid) && !$past(bus_wait));

endmodule

// File: tb/sim_pcs_bank_window.sv
module sim_pcs_bank_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        valid = 1'b0, we = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        bwait, rvalid;
   logic [1:0]  rcode;
   logic [31:0] rdata;
   logic        preq, pwe;
   logic [20:0] paddr;
   logic [15:0] pwdata;
   logic        pack = 1'b0;
   logic [15:0] prdata = '0;

   logic        v1 = 1'b0, we1 = 1'b0;
   logic [9:0]  a1 = '0;
   logic        w1, rv1, preq1, pwe1;
   logic [1:0]  rc1;
   logic [31:0] rd1;
   logic [20:0] pa1;
   logic [15:0] pwd1;

   localparam logic [9:0] BANK = 10'h3FC;
   localparam logic [1:0] OK = 2'b00, ERR = 2'b01, NODEV = 2'b10;

   pcs_bank_window u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(valid), .bus_we(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_wait(bwait), .bus_rsp_valid(rvalid),
      .bus_rsp_code(rcode), .bus_rsp_data(rdata), .pcs_req(preq), .pcs_we(pwe),
      .pcs_addr(paddr), .pcs_wdata(pwdata), .pcs_ack(pack), .pcs_rdata(prdata));

   pcs_bank_window #(.PCS_PRESENT(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_valid(v1), .bus_we(we1), .bus_addr(a1),
      .bus_wdata(32'h0000_0155), .bus_wait(w1), .bus_rsp_valid(rv1),
      .bus_rsp_code(rc1), .bus_rsp_data(rd1), .pcs_req(preq1), .pcs_we(pwe1),
      .pcs_addr(pa1), .pcs_wdata(pwd1), .pcs_ack(1'b0), .pcs_rdata(16'h0));

   int checks = 0, fails = 0;
   bit done_flag = 0;

   // PCS model: acknowledges after ack_delay cycles, data = addr[15:0] ^ 5A5A
   int          ack_delay = 0, dly = 0, fwd_count = 0, req1_count = 0;
   logic [20:0] last_addr;
   logic        last_we;
   logic [15:0] last_wd;

   initial forever begin
      @(negedge clk);
      if (pack) pack = 1'b0;
      else if (preq) begin
         if (dly >= ack_delay) begin
            pack = 1'b1;
            prdata = paddr[15:0] ^ 16'h5A5A;
            last_addr = paddr; last_we = pwe; last_wd = pwdata;
            fwd_count++;
            dly = 0;
         end else dly++;
      end
   end

   always @(posedge clk) if (preq1) req1_count++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic w, input logic [9:0] a, input logic [31:0] d,
                      output logic [1:0] code, output logic [31:0] q, output int lat);
      @(negedge clk);
      valid = 1'b1; we = w; addr = a; wdata = d;
      while (bwait) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      valid = 1'b0;
      lat = 0;
      while (!rvalid && lat < 50) begin @(negedge clk); lat++; end
      code = rcode; q = rdata;
   endtask

   task automatic acc1(input logic w, input logic [9:0] a,
                       output logic [1:0] code, output logic [31:0] q);
      @(negedge clk);
      v1 = 1'b1; we1 = w; a1 = a;
      @(posedge clk);
      @(negedge clk);
      v1 = 1'b0;
      code = rc1; q = rd1;
      chk("R8 absent rsp strobe", {31'b0, rv1}, 32'h1);
   endtask

   task automatic t_reset;
      logic [1:0] c; logic [31:0] q; int l;
      chk("R7 reset wait", {31'b0, bwait}, 32'h0);
      chk("R7 reset req", {31'b0, preq}, 32'h0);
      acc(1'b0, BANK, 0, c, q, l);
      chk("R1 reset bank", q, 32'h0);
      chk("R1 bank read code", {30'b0, c}, {30'b0, OK});
      chk("R8 local latency", l, 0);
   endtask

   task automatic t_bank;
      logic [1:0] c; logic [31:0] q; int l; int n0;
      n0 = fwd_count;
      acc(1'b1, BANK, 32'hFFFF_FF00, c, q, l);
      chk("R1 bank write code", {30'b0, c}, {30'b0, OK});
      acc(1'b0, BANK, 0, c, q, l);
      chk("R1 bank readback 13 bits", q, 32'h0000_1F00);
      chk("R1 bank no forward", fwd_count, n0);
   endtask

   task automatic t_ident;
      logic [1:0] c; logic [31:0] q; int l; int n0;
      n0 = fwd_count;
      acc(1'b0, 10'h002, 0, c, q, l);
      chk("R6 id high", q, 32'h0000_B0CA);
      acc(1'b0, 10'h003, 0, c, q, l);
      chk("R6 id low", q, 32'h0000_7E11);
      chk("R6 id code", {30'b0, c}, {30'b0, OK});
      chk("R6 id not forwarded", fwd_count, n0);
      acc(1'b1, 10'h002, 32'h0000_1234, c, q, l);
      chk("R6 id write forwarded", fwd_count, n0 + 1);
      chk("R6 id write addr", {11'b0, last_addr}, 32'h001F_0002);
   endtask

   task automatic t_write;
      logic [1:0] c; logic [31:0] q; int l;
      acc(1'b1, BANK, 32'h0000_0123, c, q, l);
      ack_delay = 1;
      acc(1'b1, 10'h045, 32'hDEAD_BEEF, c, q, l);
      chk("R2 write addr", {11'b0, last_addr}, 32'h0001_2345);
      chk("R3 write data low half", {16'b0, last_wd}, 32'h0000_BEEF);
      chk("R3 write dir", {31'b0, last_we}, 32'h1);
      chk("R8 write code", {30'b0, c}, {30'b0, OK});
      chk("R4 write rsp data", q, 32'h0);
      chk("R8 write latency", l, 2);
   endtask

   task automatic t_read;
      logic [1:0] c; logic [31:0] q; int l; logic [20:0] a0;
      acc(1'b1, BANK, 32'h0000_1ABC, c, q, l);
      ack_delay = 3;
      @(negedge clk);
      valid = 1'b1; we = 1'b0; addr = 10'h0FE;
      @(posedge clk);
      @(negedge clk);
      valid = 1'b0;
      a0 = paddr;
      chk("R7 wait while pending", {31'b0, bwait}, 32'h1);
      @(negedge clk);
      chk("R7 addr stable", {11'b0, paddr}, {11'b0, a0});
      chk("R7 still requesting", {31'b0, preq}, 32'h1);
      l = 1;
      while (!rvalid && l < 50) begin @(negedge clk); l++; end
      chk("R8 read latency", l, 4);
      chk("R2 read addr", {11'b0, last_addr}, 32'h001A_BCFE);
      chk("R4 read data", rdata, 32'h0000_E6A4);
   endtask

   task automatic t_refuse;
      logic [1:0] c; logic [31:0] q; int l; int n0;
      n0 = fwd_count;
      acc(1'b0, 10'h0FF, 0, c, q, l);
      chk("R5 offset FF refused", {30'b0, c}, {30'b0, ERR});
      acc(1'b1, 10'h0FF, 32'h1, c, q, l);
      chk("R5 offset FF write refused", {30'b0, c}, {30'b0, ERR});
      acc(1'b0, 10'h200, 0, c, q, l);
      chk("R5 unmapped refused", {30'b0, c}, {30'b0, ERR});
      chk("R5 nothing forwarded", fwd_count, n0);
   endtask

   task automatic t_overlap;
      logic [1:0] c; logic [31:0] q; int l; int n0; bit got;
      acc(1'b1, BANK, 32'h0000_0042, c, q, l);
      ack_delay = 4;
      n0 = fwd_count;
      @(negedge clk);
      valid = 1'b1; we = 1'b0; addr = 10'h010;
      @(posedge clk);
      @(negedge clk);
      we = 1'b1; addr = BANK; wdata = 32'h0000_0777;
      chk("R7 second request stalled", {31'b0, bwait}, 32'h1);
      got = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (rvalid && !got) begin
            got = 1;
            chk("R8 overlap read data", rdata, {16'b0, 16'h4210 ^ 16'h5A5A});
            chk("R7 wait low with rsp", {31'b0, bwait}, 32'h0);
         end
         if (!bwait) break;
      end
      @(posedge clk);
      @(negedge clk);
      valid = 1'b0;
      chk("R8 held write answered", {31'b0, rvalid}, 32'h1);
      acc(1'b0, BANK, 0, c, q, l);
      chk("R7 held write applied once", q, 32'h0000_0777);
      chk("R7 one transaction", fwd_count, n0 + 1);
   endtask

   task automatic t_absent;
      logic [1:0] c; logic [31:0] q;
      acc1(1'b1, BANK, c, q);
      chk("R9 bank write nodev", {30'b0, c}, {30'b0, NODEV});
      acc1(1'b0, BANK, c, q);
      chk("R9 bank read nodev", {30'b0, c}, {30'b0, NODEV});
      acc1(1'b0, 10'h010, c, q);
      chk("R9 data read nodev", {30'b0, c}, {30'b0, NODEV});
      acc1(1'b1, 10'h011, c, q);
      chk("R9 data write nodev", {30'b0, c}, {30'b0, NODEV});
      chk("R9 no request", req1_count, 0);
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_bank();
      t_ident();
      t_write();
      t_read();
      t_refuse();
      t_overlap();
      t_absent();
      repeat (3) @(posedge clk);
      finish_run();
   end

endmodule